// File: doc/BRIEF.md
# Packed Single-Precision Square Root Unit

The unit takes a packed vector of IEEE-754 single-precision values and returns their square roots, one per 32-bit lane, rounded to nearest with ties to even. The caller presents a 256-bit source, the present 256-bit contents of the destination register, a two-bit encoding mode and a four-bit specifier field, then pulses `start`. The unit latches these, works through the active lanes one after another on a single restoring digit-recurrence root datapath, and pulses `done` when the merged 256-bit image on `result` is ready. That image is meant to be written back to the register file.

The mode sets how many lanes are computed and what happens to the upper 128 bits. In the legacy 128-bit mode the upper half is carried over from the destination. In the VEX 128-bit mode it is cleared. In the VEX 256-bit mode it is filled by four more lanes. Special operands are resolved without using the datapath. The invalid, denormal-operand and inexact conditions of every lane are ORed into sticky flags, which stay set until `flag_clr` is pulsed. An illegal specifier, or the reserved mode, rejects the operation: the unit raises `fault` together with `done` and writes neither the result nor the flags.

The controller is a four-state machine:
- IDLE waits for `start`. It goes to DONE when the operation is illegal and to PREP otherwise.
- PREP classifies the current lane. A special lane is written at once, and the machine stays in PREP for the next lane or goes to DONE after the last one. A lane that needs a root loads the datapath and the machine goes to ROOT.
- ROOT waits for the datapath to finish, rounds the root and writes the lane, then goes to PREP for the next lane or to DONE after the last one.
- DONE drives `done` for one cycle and returns to IDLE.

Top module: `psqrt_unit`

## Requirements
- R1: In modes 2'b00 (legacy 128-bit) and 2'b01 (VEX 128-bit), four lanes are computed. Source bits [32k+31:32k], k=0..3, give result bits [32k+31:32k]. Each lane is the correctly rounded (round to nearest, ties to even) square root.
- R2: In mode 2'b10 (VEX 256-bit), eight lanes k=0..7 are computed with the same lane-to-position mapping.
- R3: In mode 2'b00, result bits [255:128] equal `dst_in[255:128]` as sampled at `start`.
- R4: In mode 2'b01, result bits [255:128] are zero.
- R5: When the mode is 2'b11, or the mode is 2'b01 or 2'b10 and `spec` is not 4'b1111, `fault` is high in the `done` cycle and `result` and `flags` keep their previous values. In mode 2'b00, `spec` is ignored.
- R6: A lane holding a signaling NaN (exponent all ones, fraction nonzero, fraction bit 22 clear) or a negative nonzero value gives 32'h7FC00000 and raises invalid. A quiet NaN (fraction bit 22 set) is returned unchanged and raises no flag.
- R7: +0 and -0 are returned unchanged, and +Inf returns +Inf. None of these raise a flag.
- R8: A subnormal lane with `daz` low raises denormal and is normalized before its root is taken. A subnormal lane with `daz` high gives a zero of the same sign and raises no flag.
- R9: The inexact flag is raised when some computed lane's root is not exact, meaning its round bit or its final remainder is nonzero.
- R10: `flags` is {inexact, denormal, invalid} in bits [2:0]. It holds the OR over all lanes of all completed operations since the last `flag_clr` pulse, and `flag_clr` clears it.
- R11: `busy` goes high in the cycle after an accepted `start` and stays high up to and including the single `done` cycle, which follows the last lane. A `start` while `busy` is high is ignored.
- R12: After reset, `busy`, `done` and `fault` are low and `result` and `flags` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 2 | 00 legacy 128-bit, 01 VEX 128-bit, 10 VEX 256-bit, 11 reserved |
| spec | input | 4 | Register-specifier field, must be 4'b1111 in VEX modes |
| daz | input | 1 | Treat subnormal operands as signed zero |
| flag_clr | input | 1 | Clear the sticky flags |
| src | input | 256 | Packed source operands |
| dst_in | input | 256 | Present destination contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation rejected (undefined opcode), valid with done |
| result | output | 256 | Merged destination image |
| flags | output | 3 | Sticky {inexact, denormal, invalid} |

## Verification
Exact squares such as 1, 4 and 9 are run next to non-squares such as 2. This tells a correct root and correct rounding apart from a merely plausible mantissa, and it separates operations that leave the inexact flag clear from operations that set it. Vectors that mix zeros of both signs, infinities, quiet and signaling NaNs, negative values and subnormals, with `daz` low and high, check that each special path is taken in the right order of precedence. Random vectors in all three modes are checked with `dst_in` carrying a distinct pattern, which shows the upper-half policy. Illegal specifiers, the reserved mode, flag accumulation without a clear, and a second `start` during a busy operation complete the set.

// File: rtl/psqrt_pkg.sv
package psqrt_pkg;
    typedef enum logic [1:0] {
        MD_LEG  = 2'b00,
        MD_V128 = 2'b01,
        MD_V256 = 2'b10,
        MD_RSV  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_PREP = 2'b01,
        S_ROOT = 2'b10,
        S_DONE = 2'b11
    } state_e;

    localparam int          FP_W     = 32;
    localparam int          MANT_W   = 24;
    localparam int          ROOT_W   = MANT_W + 1;
    localparam int          RAD_W    = 2 * ROOT_W;
    localparam logic [31:0] QNAN_DEF = 32'h7FC0_0000;
endpackage

// File: rtl/psqrt_lane_prep.sv
module psqrt_lane_prep
    import psqrt_pkg::*;
(
    input  logic [FP_W-1:0]  word,
    input  logic             daz,
    output logic             special,
    output logic [FP_W-1:0]  spc_val,
    output logic             inv,
    output logic             den,
    output logic [RAD_W-1:0] rad,
    output logic [7:0]       exp_b
);
    logic              sgn;
    logic [7:0]        ex;
    logic [22:0]       fr;
    logic [4:0]        sh;
    logic [MANT_W-1:0] m24;
    logic signed [9:0] e_unb;
    logic signed [9:0] e_half;

    assign sgn = word[31];
    assign ex  = word[30:23];
    assign fr  = word[22:0];

    function automatic logic [4:0] lead_zeros(input logic [MANT_W-1:0] v);
        logic [4:0] n;
        logic       hit;
        n   = '0;
        hit = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) hit = 1'b1;
            else if (!hit) n = n + 5'd1;
        end
        return n;
    endfunction

    always_comb begin
        special = 1'b1;
        spc_val = word;
        inv     = 1'b0;
        den     = 1'b0;
        if (ex == 8'hFF && fr != '0) begin
            if (!fr[22]) begin
                spc_val = QNAN_DEF;
                inv     = 1'b1;
            end
        end else if (ex == 8'h00 && (fr == '0 || daz)) begin
            spc_val = {sgn, 31'b0};
        end else begin
            den = (ex == 8'h00);
            if (sgn) begin
                spc_val = QNAN_DEF;
                inv     = 1'b1;
            end else if (ex == 8'hFF) begin
                spc_val = word;
            end else begin
                special = 1'b0;
            end
        end
    end

    always_comb begin
        sh = lead_zeros({1'b0, fr});
        if (ex == 8'h00) begin
            m24   = {1'b0, fr} << sh;
            e_unb = -10'sd126 - $signed({5'b0, sh});
        end else begin
            m24   = {1'b1, fr};
            e_unb = $signed({2'b0, ex}) - 10'sd127;
        end
        e_half = e_unb >>> 1;
        exp_b  = 8'(e_half + 10'sd127);
        if (e_unb[0]) rad = {m24, {(RAD_W - MANT_W){1'b0}}};
        else          rad = {1'b0, m24, {(RAD_W - MANT_W - 1){1'b0}}};
    end
endmodule

// File: rtl/psqrt_root_core.sv
module psqrt_root_core
    import psqrt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [RAD_W-1:0]  rad,
    output logic              fin,
    output logic [ROOT_W-1:0] root,
    output logic              rem_nz
);
    localparam int RW  = ROOT_W + 3;
    localparam int CNW = $clog2(ROOT_W + 1);

    logic [RAD_W-1:0]  rad_q;
    logic [RW-1:0]     rem_q;
    logic [ROOT_W-1:0] root_q;
    logic [CNW-1:0]    cnt_q;
    logic              fin_q;
    logic [RW-1:0]     cur;
    logic [RW-1:0]     trial;
    logic              take;

    assign cur   = {rem_q[RW-3:0], rad_q[RAD_W-1 -: 2]};
    assign trial = {1'b0, root_q, 2'b01};
    assign take  = (cur >= trial);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rad_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= '0;
            fin_q  <= 1'b0;
        end else if (load) begin
            rad_q  <= rad;
            rem_q  <= '0;
            root_q <= '0;
            cnt_q  <= CNW'(ROOT_W);
            fin_q  <= 1'b0;
        end else if (cnt_q != '0) begin
            rad_q  <= rad_q << 2;
            rem_q  <= take ? (cur - trial) : cur;
            root_q <= {root_q[ROOT_W-2:0], take};
            cnt_q  <= cnt_q - 1'b1;
            fin_q  <= (cnt_q == CNW'(1));
        end else begin
            fin_q  <= 1'b0;
        end
    end

    assign fin    = fin_q;
    assign root   = root_q;
    assign rem_nz = (rem_q != '0);

    a_r11_core_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    a_r1_core_idle_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (cnt_q == '0));
endmodule

// File: rtl/psqrt_round.sv
module psqrt_round
    import psqrt_pkg::*;
(
    input  logic [ROOT_W-1:0] root,
    input  logic              rem_nz,
    input  logic [7:0]        exp_b,
    output logic [FP_W-1:0]   word,
    output logic              inexact
);
    logic              inc;
    logic [MANT_W:0]   sum;

    always_comb begin
        inc     = root[0] & (rem_nz | root[1]);
        sum     = {1'b0, root[ROOT_W-1:1]} + {{MANT_W{1'b0}}, inc};
        inexact = root[0] | rem_nz;
        if (sum[MANT_W]) word = {1'b0, exp_b + 8'd1, sum[MANT_W-1:1]};
        else             word = {1'b0, exp_b, sum[MANT_W-2:0]};
    end
endmodule

// File: rtl/psqrt_unit.sv
module psqrt_unit
    import psqrt_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic [3:0]            spec,
    input  logic                  daz,
    input  logic                  flag_clr,
    input  logic [LANES*FP_W-1:0] src,
    input  logic [LANES*FP_W-1:0] dst_in,
    output logic                  busy,
    output logic                  done,
    output logic                  fault,
    output logic [LANES*FP_W-1:0] result,
    output logic [2:0]            flags
);
    localparam int VW = LANES * FP_W;
    localparam int HW = VW / 2;
    localparam int LW = $clog2(LANES);

    state_e          state_q, state_d;
    logic [VW-1:0]   src_q, dst_q, work_q, work_mrg, result_q;
    mode_e           mode_q;
    logic            daz_q, fault_q;
    logic [LW-1:0]   lane_q;
    logic [2:0]      pend_q, flags_q, lane_fl;
    logic [7:0]      exp_q;
    logic            bad_req, last_lane, lane_wr, lane_fl_en, core_load;
    logic [LW:0]     n_act;
    logic [FP_W-1:0] cur_word, lane_val;

    logic             p_special, p_inv, p_den;
    logic [FP_W-1:0]  p_val;
    logic [RAD_W-1:0] p_rad;
    logic [7:0]       p_exp;
    logic             c_fin, c_rem_nz;
    logic [ROOT_W-1:0] c_root;
    logic [FP_W-1:0]  r_word;
    logic             r_inexact;

    assign bad_req   = (mode_e'(mode) == MD_RSV) ||
                       (mode_e'(mode) != MD_LEG && spec != 4'hF);
    assign n_act     = (mode_q == MD_V256) ? (LW+1)'(LANES) : (LW+1)'(LANES / 2);
    assign last_lane = ({1'b0, lane_q} == n_act - 1'b1);
    assign cur_word  = src_q[lane_q*FP_W +: FP_W];

    psqrt_lane_prep u_prep (
        .word    (cur_word),
        .daz     (daz_q),
        .special (p_special),
        .spc_val (p_val),
        .inv     (p_inv),
        .den     (p_den),
        .rad     (p_rad),
        .exp_b   (p_exp)
    );

    psqrt_root_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (core_load),
        .rad    (p_rad),
        .fin    (c_fin),
        .root   (c_root),
        .rem_nz (c_rem_nz)
    );

    psqrt_round u_round (
        .root    (c_root),
        .rem_nz  (c_rem_nz),
        .exp_b   (exp_q),
        .word    (r_word),
        .inexact (r_inexact)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = bad_req ? S_DONE : S_PREP;
            S_PREP: begin
                if (!p_special)     state_d = S_ROOT;
                else if (last_lane) state_d = S_DONE;
            end
            S_ROOT: if (c_fin) state_d = last_lane ? S_DONE : S_PREP;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // lane write control
    always_comb begin
        lane_wr    = 1'b0;
        lane_val   = p_val;
        lane_fl    = 3'b000;
        lane_fl_en = 1'b0;
        core_load  = 1'b0;
        unique case (state_q)
            S_PREP: begin
                lane_fl    = {1'b0, p_den, p_inv};
                lane_fl_en = 1'b1;
                lane_wr    = p_special;
                core_load  = !p_special;
            end
            S_ROOT: begin
                lane_val   = r_word;
                lane_fl    = {r_inexact, 2'b00};
                lane_fl_en = c_fin;
                lane_wr    = c_fin;
            end
            default: ;
        endcase
    end

    always_comb begin
        work_mrg = work_q;
        work_mrg[lane_q*FP_W +: FP_W] = lane_val;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            work_q   <= '0;
            result_q <= '0;
            mode_q   <= MD_LEG;
            daz_q    <= 1'b0;
            fault_q  <= 1'b0;
            lane_q   <= '0;
            pend_q   <= '0;
            flags_q  <= '0;
            exp_q    <= '0;
        end else begin
            flags_q <= (flag_clr ? 3'b000 : flags_q) |
                       ((lane_wr && last_lane) ? (pend_q | lane_fl) : 3'b000);
            if (state_q == S_IDLE && start) begin
                src_q   <= src;
                dst_q   <= dst_in;
                mode_q  <= mode_e'(mode);
                daz_q   <= daz;
                fault_q <= bad_req;
                lane_q  <= '0;
                pend_q  <= '0;
                work_q  <= (mode_e'(mode) == MD_LEG) ? {dst_in[VW-1:HW], {HW{1'b0}}} : '0;
            end
            if (state_q == S_PREP && !p_special) exp_q <= p_exp;
            if (lane_fl_en) pend_q <= pend_q | lane_fl;
            if (lane_wr) begin
                work_q <= work_mrg;
                if (last_lane) result_q <= work_mrg;
                else           lane_q   <= lane_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        fault  = (state_q == S_DONE) && fault_q;
        result = result_q;
        flags  = flags_q;
    end

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r5_fault_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> done);
    a_r5_fault_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $stable(result));
    a_r5_fault_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !$past(flag_clr)) |-> $stable(flags));
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && mode_q == MD_LEG) |-> (result[VW-1:HW] == dst_q[VW-1:HW]));
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && mode_q == MD_V128) |-> (result[VW-1:HW] == '0));
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(lane_wr && last_lane)) |=> (flags == 3'b000));
endmodule

// File: tb/psqrt_unit_tb_top.sv
`timescale 1ns/1ps
module psqrt_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [3:0]   spec = 4'hF;
    logic         daz = 1'b0;
    logic         flag_clr = 1'b0;
    logic [255:0] src = '0;
    logic [255:0] dst_in = '0;
    logic         busy, done, fault;
    logic [255:0] result;
    logic [2:0]   flags;

    int checks = 0;
    int errors = 0;
    logic [255:0] m_result = '0;
    logic [2:0]   m_flags = '0;

    always #5 clk = ~clk;

    psqrt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .spec(spec),
        .daz(daz), .flag_clr(flag_clr), .src(src), .dst_in(dst_in),
        .busy(busy), .done(done), .fault(fault), .result(result), .flags(flags)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference lane: {inexact, denormal, invalid}
    function automatic logic [31:0] ref_lane(input logic [31:0] w, input bit dz,
                                             output logic [2:0] fl);
        logic sg = w[31];
        logic [7:0] e = w[30:23];
        logic [22:0] f = w[22:0];
        longint unsigned mant, rad, lo, hi, mid, q, mm;
        int unb, er;
        bit sticky, g, incr;
        fl = 3'b000;
        if (e == 8'hFF && f != 0) begin
            if (f[22]) return w;
            fl[0] = 1'b1; return 32'h7FC00000;
        end
        if (e == 0 && (f == 0 || dz)) return {sg, 31'b0};
        if (e == 0) fl[1] = 1'b1;
        if (sg) begin fl[0] = 1'b1; return 32'h7FC00000; end
        if (e == 8'hFF) return w;
        if (e == 0) begin
            mant = longint'(f); unb = -126;
            while (mant < (64'd1 << 23)) begin mant = mant << 1; unb--; end
        end else begin
            mant = longint'(f) | (64'd1 << 23); unb = int'(e) - 127;
        end
        if ((unb % 2) != 0) begin rad = mant << 26; er = (unb - 1) / 2; end
        else begin rad = mant << 25; er = unb / 2; end
        lo = 0; hi = (64'd1 << 25) - 1;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= rad) lo = mid; else hi = mid - 1;
        end
        sticky = (lo * lo != rad);
        g = lo[0];
        q = lo >> 1;
        incr = g && (sticky || q[0]);
        mm = q + (incr ? 1 : 0);
        er = er + 127;
        if (mm >= (64'd1 << 24)) begin mm = mm >> 1; er++; end
        if (g || sticky) fl[2] = 1'b1;
        return {1'b0, 8'(er), mm[22:0]};
    endfunction

    task automatic run_op(input logic [1:0] md, input logic [3:0] sp, input bit dz,
                          input logic [255:0] s, input logic [255:0] d, input string tag);
        logic [255:0] er;
        logic [2:0] ef, lf;
        bit bad;
        int n;
        bad = (md == 2'b11) || (md != 2'b00 && sp != 4'hF);
        er = '0; ef = 3'b000;
        n = (md == 2'b10) ? 8 : 4;
        if (md == 2'b00) er[255:128] = d[255:128];
        for (int k = 0; k < n; k++) begin
            er[k*32 +: 32] = ref_lane(s[k*32 +: 32], dz, lf);
            ef = ef | lf;
        end
        if (!bad) begin m_result = er; m_flags = m_flags | ef; end
        @(negedge clk);
        mode = md; spec = sp; daz = dz; src = s; dst_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        src = ~s; dst_in = ~d;
        chk(busy == 1'b1, "R11", "busy after start", 256'(busy), 256'(1));
        while (!done) @(negedge clk);
        chk(fault == bad, bad ? "R5" : tag, "fault", 256'(fault), 256'(bad));
        chk(result == m_result, bad ? "R5" : tag, "result", result, m_result);
        chk(flags == m_flags, bad ? "R5" : "R10", "flags", 256'(flags), 256'(m_flags));
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11", "idle after done",
            256'({busy, done}), 256'(0));
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        m_flags = 3'b000;
        chk(flags == 3'b000, "R10", "flags cleared", 256'(flags), 256'(0));
    endtask

    function automatic logic [31:0] rnd_lane();
        logic [31:0] r = $urandom;
        int c = $urandom % 16;
        unique case (c)
            0: return {r[31], 31'b0};
            1: return {r[31], 8'hFF, 23'b0};
            2: return {r[31], 8'hFF, 1'b1, r[21:0]};
            3: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            4: return {r[31], 8'h00, r[22:1], 1'b1};
            5: return {1'b1, 8'(1 + r[30:23] % 254), r[22:0]};
            default: return {1'b0, 8'(1 + r[30:23] % 254), r[22:0]};
        endcase
    endfunction

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = rnd_lane();
        return v;
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] dpat, ea, sa;
        logic [2:0] lf;
        bit extra;
        void'($urandom(32'd20240611));
        dpat = {8{32'hA5C3_0F1E}};
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 0 && done == 0 && fault == 0, "R12", "control outputs",
            256'({busy, done, fault}), 256'(0));
        chk(result == '0 && flags == 3'b000, "R12", "result and flags",
            {result[252:0], flags}, 256'(0));
        rst_n = 1'b1;

        // R1 and R9: exact squares then a non-square
        run_op(2'b01, 4'hF, 1'b0,
               {128'h0, 32'h41100000, 32'h3F800000, 32'h41800000, 32'h40800000}, dpat, "R1");
        chk(result[31:0] == 32'h40000000 && result[127:96] == 32'h40400000, "R1",
            "sqrt 4 and 9", result, m_result);
        chk(flags == 3'b000, "R9", "exact roots leave inexact low", 256'(flags), 256'(0));
        run_op(2'b01, 4'hF, 1'b0,
               {128'h0, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h40000000}, dpat, "R1");
        chk(result[31:0] == 32'h3FB504F3, "R1", "sqrt 2 rounded", result, 256'h3FB504F3);
        chk(flags[2] == 1'b1, "R9", "inexact raised", 256'(flags), 256'(4));
        clear_flags();

        // R6 and R7: specials in 256-bit mode
        run_op(2'b10, 4'hF, 1'b0,
               {32'h3F800000, 32'hFF800000, 32'hBF800000, 32'h7F800001,
                32'hFFC12345, 32'h7F800000, 32'h80000000, 32'h00000000}, dpat, "R6");
        chk(result[63:0] == 64'h80000000_00000000 && result[95:64] == 32'h7F800000, "R7",
            "zeros and infinity", result, m_result);
        chk(result[127:96] == 32'hFFC12345 && result[159:128] == 32'h7FC00000, "R6",
            "quiet NaN kept, signaling NaN defaulted", result, m_result);
        clear_flags();
        run_op(2'b10, 4'hF, 1'b0,
               {32'h3F800000, 32'h7F800000, 32'hFFC00001, 32'h80000000,
                32'h00000000, 32'h7FC00000, 32'h40800000, 32'h41100000}, dpat, "R7");
        chk(flags == 3'b000, "R7", "no flags from zeros, infinity, quiet NaN",
            256'(flags), 256'(0));

        // R8: subnormals with and without daz
        clear_flags();
        run_op(2'b00, 4'h3, 1'b0,
               {128'h0, 32'h3F800000, 32'h80000001, 32'h00400000, 32'h00000001}, dpat, "R8");
        chk(result[31:0] == ref_lane(32'h00000001, 1'b0, lf) && flags[1], "R8",
            "smallest subnormal root", result, m_result);
        clear_flags();
        run_op(2'b00, 4'hF, 1'b1,
               {128'h0, 32'h3F800000, 32'h80000001, 32'h00400000, 32'h00000001}, dpat, "R8");
        chk(result[95:0] == {32'h80000000, 64'h0} && flags == 3'b000, "R8",
            "daz gives signed zero without flags", result, {160'h0, 32'h80000000, 64'h0});

        // R5: rejected operations
        sa = rnd_vec();
        run_op(2'b01, 4'hE, 1'b0, sa, dpat, "R5");
        run_op(2'b10, 4'h0, 1'b0, sa, dpat, "R5");
        run_op(2'b11, 4'hF, 1'b0, sa, dpat, "R5");
        run_op(2'b00, 4'h0, 1'b0, sa, dpat, "R3");

        // R10: accumulation across operations without a clear
        clear_flags();
        run_op(2'b01, 4'hF, 1'b0, {128'h0, 96'h0, 32'hBF800000}, dpat, "R10");
        run_op(2'b01, 4'hF, 1'b0, {128'h0, {4{32'h40800000}}}, dpat, "R10");
        chk(flags == 3'b001, "R10", "invalid stays set", 256'(flags), 256'(1));
        clear_flags();

        // R11: start while busy is ignored
        sa = {8{32'h40000000}};
        for (int k = 0; k < 8; k++) ea[k*32 +: 32] = ref_lane(sa[k*32 +: 32], 1'b0, lf);
        @(negedge clk);
        mode = 2'b10; spec = 4'hF; daz = 1'b0; src = sa; dst_in = dpat; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        src = {8{32'h41100000}}; mode = 2'b01; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk(result == ea, "R11", "second start ignored", result, ea);
        m_result = ea; m_flags = 3'b100;
        extra = 1'b0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done) extra = 1'b1;
        end
        chk(!extra, "R11", "no second done", 256'(extra), 256'(0));
        clear_flags();

        // random vectors in all legal modes
        for (int i = 0; i < 45; i++) begin
            logic [1:0] md;
            md = 2'($urandom % 3);
            dpat = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            run_op(md, 4'hF, bit'($urandom % 4 == 0), rnd_vec(), dpat,
                   md == 2'b00 ? "R3" : (md == 2'b01 ? "R4" : "R2"));
            if (i % 9 == 8) clear_flags();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule